// File: doc/BRIEF.md
# Dual Wiper Register Command Executor

This block holds the position codes of two digitally controlled resistor wipers and applies decoded commands to them. A serial front end hands over one command at a time as a 4-bit opcode, a 4-bit address and an 8-bit data byte, qualified by a one-cycle valid strobe. The executor can write a code directly, step a wiper up or down by one position, or move it by roughly 6 dB by doubling or halving the code. Each of these operations targets either the channel picked by the address or both channels at once.

Code 0 puts a wiper at the B end of its track, the midscale code 128 puts it at mid-track and code 255 puts it at the A end. The executor does not touch nonvolatile storage itself. Save and recall opcodes become one-cycle request pulses for a separate storage controller. A read opcode captures the addressed wiper code into a readback byte for the serial front end to shift out.

Top module: `wiper_exec`

## Requirements
- R1: After reset both wiper outputs read the midscale code 128, readByte reads 0 and both request pulses are low. Code 0 maps to the B end and 255 to the A end.
- R2: Opcode 11 writes cmdData into one wiper. Address bit 0 picks the wiper: 0 selects wiper0 and 1 selects wiper1. The new value appears at the clock edge that samples cmdValid high.
- R3: Opcode 14 adds one to the addressed wiper and opcode 15 adds one to both wipers. A wiper already at 255 stays at 255.
- R4: Opcode 6 subtracts one from the addressed wiper and opcode 7 subtracts one from both wipers. A wiper already at 0 stays at 0.
- R5: Opcode 12 (addressed wiper) and opcode 13 (both wipers) double the code. Code 0 becomes 1, any code of 128 or more becomes 255, and 255 stays at 255.
- R6: Opcode 4 (addressed wiper) and opcode 5 (both wipers) halve the code, rounding down, so 1 becomes 0 and 0 stays at 0.
- R7: The step and shift opcodes ignore cmdData. A single-wiper opcode leaves the other wiper unchanged.
- R8: Opcode 0 changes no wiper. Neither does any opcode not listed in these requirements, nor any cycle in which cmdValid is low.
- R9: Opcode 2 raises nvSaveReq for exactly one cycle. Opcode 1 raises nvRecallReq for one cycle with nvAll low, and opcode 8 raises it for one cycle with nvAll high. While a request is high, nvChan carries address bit 0.
- R10: Opcode 10 loads readByte with the addressed wiper code, using address bit 0 as in R2. readByte keeps its value until the next opcode 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe, high for one cycle per command |
| cmdCode | input | 4 | Opcode |
| cmdAddr | input | 4 | Address, bit 0 selects the wiper |
| cmdData | input | 8 | Data byte for direct writes |
| wiper0 | output | 8 | Code of wiper 0 |
| wiper1 | output | 8 | Code of wiper 1 |
| readByte | output | 8 | Readback byte |
| nvSaveReq | output | 1 | One-cycle request to store a wiper code in nonvolatile memory |
| nvRecallReq | output | 1 | One-cycle request to reload wiper codes from nonvolatile memory |
| nvAll | output | 1 | Recall request applies to both wipers |
| nvChan | output | 1 | Wiper addressed by a save or single recall request |

## Verification
The bench targets the corner cases of the doubling opcode. A design that shifts code 0 plainly would leave it at 0, and one that shifts codes of 128 or more plainly would drop the top bit and fall to a low code instead of jumping to 255. Step opcodes are driven at both ends of the range, where a missing saturation shows up as a wrap from 255 to 0 or from 0 to 255. Single-wiper opcodes are checked against the untouched wiper so that a wrong address decode is caught. Step and shift opcodes are sent with nonzero data bytes, so a design that loads cmdData on those opcodes is caught.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  localparam int NUM_CH = 2;
  localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  localparam logic [3:0] OP_NOP        = 4'd0;
  localparam logic [3:0] OP_RECALL_ONE = 4'd1;
  localparam logic [3:0] OP_SAVE_ONE   = 4'd2;
  localparam logic [3:0] OP_SHR_ONE    = 4'd4;
  localparam logic [3:0] OP_SHR_ALL    = 4'd5;
  localparam logic [3:0] OP_DEC_ONE    = 4'd6;
  localparam logic [3:0] OP_DEC_ALL    = 4'd7;
  localparam logic [3:0] OP_RECALL_ALL = 4'd8;
  localparam logic [3:0] OP_READ       = 4'd10;
  localparam logic [3:0] OP_LOAD       = 4'd11;
  localparam logic [3:0] OP_SHL_ONE    = 4'd12;
  localparam logic [3:0] OP_SHL_ALL    = 4'd13;
  localparam logic [3:0] OP_INC_ONE    = 4'd14;
  localparam logic [3:0] OP_INC_ALL    = 4'd15;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LOAD,
    ACT_INC,
    ACT_DEC,
    ACT_SHL,
    ACT_SHR
  } act_e;

  typedef struct packed {
    act_e              act;
    logic [NUM_CH-1:0] sel;
    logic              rd;
    logic [SEL_W-1:0]  chan;
  } strobe_t;

endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [3:0] cmdCode,
  input  logic [3:0] cmdAddr,
  output strobe_t    strobe,
  output logic       nvSaveReq,
  output logic       nvRecallReq,
  output logic       nvAll,
  output logic       nvChan
);

  logic [NUM_CH-1:0] oneSel;
  logic              isAll;
  act_e              act;
  logic              saveNext;
  logic              recallNext;

  always_comb begin
    oneSel = '0;
    oneSel[cmdAddr[SEL_W-1:0]] = 1'b1;
  end

  always_comb begin
    act        = ACT_NONE;
    isAll      = 1'b0;
    saveNext   = 1'b0;
    recallNext = 1'b0;
    if (cmdValid) begin
      case (cmdCode)
        OP_LOAD:       act = ACT_LOAD;
        OP_INC_ONE:    act = ACT_INC;
        OP_INC_ALL:    begin act = ACT_INC; isAll = 1'b1; end
        OP_DEC_ONE:    act = ACT_DEC;
        OP_DEC_ALL:    begin act = ACT_DEC; isAll = 1'b1; end
        OP_SHL_ONE:    act = ACT_SHL;
        OP_SHL_ALL:    begin act = ACT_SHL; isAll = 1'b1; end
        OP_SHR_ONE:    act = ACT_SHR;
        OP_SHR_ALL:    begin act = ACT_SHR; isAll = 1'b1; end
        OP_SAVE_ONE:   saveNext = 1'b1;
        OP_RECALL_ONE: recallNext = 1'b1;
        OP_RECALL_ALL: begin recallNext = 1'b1; isAll = 1'b1; end
        default:       act = ACT_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.act  = act;
    strobe.sel  = (act == ACT_NONE) ? '0 : (isAll ? '1 : oneSel);
    strobe.rd   = cmdValid && (cmdCode == OP_READ);
    strobe.chan = cmdAddr[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nvSaveReq   <= 1'b0;
      nvRecallReq <= 1'b0;
      nvAll       <= 1'b0;
      nvChan      <= 1'b0;
    end else begin
      nvSaveReq   <= saveNext;
      nvRecallReq <= recallNext;
      nvAll       <= recallNext && isAll;
      nvChan      <= cmdAddr[0];
    end
  end

endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [CODE_W-1:0] dataIn,
  output logic [CODE_W-1:0] codes [NUM_CH],
  output logic [CODE_W-1:0] readByte
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

  function automatic logic [CODE_W-1:0] nextCode(
    input act_e              a,
    input logic [CODE_W-1:0] cur,
    input logic [CODE_W-1:0] din
  );
    logic [CODE_W-1:0] r;
    case (a)
      ACT_LOAD: r = din;
      ACT_INC:  r = (cur == CODE_MAX) ? cur : cur + CODE_ONE;
      ACT_DEC:  r = (cur == '0) ? cur : cur - CODE_ONE;
      ACT_SHL: begin
        if (cur == '0)             r = CODE_ONE;
        else if (cur >= CODE_MID)  r = CODE_MAX;
        else                       r = cur << 1;
      end
      ACT_SHR:  r = cur >> 1;
      default:  r = cur;
    endcase
    return r;
  endfunction

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codes[ch] <= CODE_MID;
      end else if (strobe.sel[ch]) begin
        codes[ch] <= nextCode(strobe.act, codes[ch], dataIn);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readByte <= '0;
    end else if (strobe.rd) begin
      readByte <= codes[strobe.chan];
    end
  end

endmodule

// File: rtl/wiper_exec.sv
module wiper_exec
  import wiper_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdCode,
  input  logic [3:0]        cmdAddr,
  input  logic [CODE_W-1:0] cmdData,
  output logic [CODE_W-1:0] wiper0,
  output logic [CODE_W-1:0] wiper1,
  output logic [CODE_W-1:0] readByte,
  output logic              nvSaveReq,
  output logic              nvRecallReq,
  output logic              nvAll,
  output logic              nvChan
);

  strobe_t           strobe;
  logic [CODE_W-1:0] codes [NUM_CH];

  wiper_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdCode     (cmdCode),
    .cmdAddr     (cmdAddr),
    .strobe      (strobe),
    .nvSaveReq   (nvSaveReq),
    .nvRecallReq (nvRecallReq),
    .nvAll       (nvAll),
    .nvChan      (nvChan)
  );

  wiper_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (cmdData),
    .codes    (codes),
    .readByte (readByte)
  );

  assign wiper0 = codes[0];
  assign wiper1 = codes[1];

endmodule

// File: rtl/wiper_exec_chk.sv
module wiper_exec_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [3:0]        cmdCode,
  input logic [3:0]        cmdAddr,
  input logic [CODE_W-1:0] cmdData,
  input logic [CODE_W-1:0] wiper0,
  input logic [CODE_W-1:0] wiper1,
  input logic [CODE_W-1:0] readByte,
  input logic              nvSaveReq,
  input logic              nvRecallReq,
  input logic              nvAll,
  input logic              nvChan
);

  localparam logic [CODE_W-1:0] CMAX = '1;
  localparam logic [CODE_W-1:0] CMID = CODE_W'(1) << (CODE_W - 1);

  p_load_w0_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 4'd11 && !cmdAddr[0] |=> wiper0 == $past(cmdData));

  p_inc_sat_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 4'd15 && wiper1 == CMAX |=> wiper1 == CMAX);

  p_dec_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 4'd7 && wiper0 == '0 |=> wiper0 == '0);

  p_shl_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 4'd13 && wiper0 == '0 |=> wiper0 == CODE_W'(1));

  p_shl_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 4'd13 && wiper1 >= CMID |=> wiper1 == CMAX);

  p_shr_halve_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 4'd5 |=> wiper0 == ($past(wiper0) >> 1));

  p_other_chan_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdAddr[0] && (cmdCode == 4'd14 || cmdCode == 4'd6 ||
      cmdCode == 4'd12 || cmdCode == 4'd4 || cmdCode == 4'd11) |=> $stable(wiper1));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(wiper0) && $stable(wiper1));

  p_save_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    nvSaveReq |=> !nvSaveReq || $past(cmdValid && cmdCode == 4'd2));

  p_req_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nvSaveReq, nvRecallReq}));

  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdCode == 4'd10) |=> $stable(readByte));

endmodule

bind wiper_exec wiper_exec_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdCode     (cmdCode),
  .cmdAddr     (cmdAddr),
  .cmdData     (cmdData),
  .wiper0      (wiper0),
  .wiper1      (wiper1),
  .readByte    (readByte),
  .nvSaveReq   (nvSaveReq),
  .nvRecallReq (nvRecallReq),
  .nvAll       (nvAll),
  .nvChan      (nvChan)
);

// File: tb/wiper_exec_bench.sv
`timescale 1ns/1ps
module wiper_exec_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [3:0] cmdCode = '0;
  logic [3:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic [7:0] wiper0, wiper1, readByte;
  logic       nvSaveReq, nvRecallReq, nvAll, nvChan;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mW [2];
  logic [7:0] mRd;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wiper_exec u_wiper_exec (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wiper0(wiper0), .wiper1(wiper1),
    .readByte(readByte), .nvSaveReq(nvSaveReq), .nvRecallReq(nvRecallReq),
    .nvAll(nvAll), .nvChan(nvChan)
  );

  function automatic logic [7:0] stepModel(input logic [3:0] op, input logic [7:0] c,
                                           input logic [7:0] d);
    case (op)
      4'd11:        return d;
      4'd14, 4'd15: return (c == 8'd255) ? 8'd255 : c + 8'd1;
      4'd6, 4'd7:   return (c == 8'd0) ? 8'd0 : c - 8'd1;
      4'd12, 4'd13: return (c == 8'd0) ? 8'd1 : ((c >= 8'd128) ? 8'd255 : {c[6:0], 1'b0});
      4'd4, 4'd5:   return {1'b0, c[7:1]};
      default:      return c;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd11:        return "R2";
      4'd14, 4'd15: return "R3";
      4'd6, 4'd7:   return "R4";
      4'd12, 4'd13: return "R5";
      4'd4, 4'd5:   return "R6";
      4'd1, 4'd2, 4'd8: return "R9";
      4'd10:        return "R10";
      default:      return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runCmd(input bit v, input logic [3:0] op, input logic [3:0] a,
                        input logic [7:0] d);
    bit single, all, expSave, expRecall, expAll;
    string rq;
    @(negedge clk);
    cmdValid = v; cmdCode = op; cmdAddr = a; cmdData = d;
    single = (op == 4'd11 || op == 4'd14 || op == 4'd6 || op == 4'd12 || op == 4'd4);
    all    = (op == 4'd15 || op == 4'd7 || op == 4'd13 || op == 4'd5);
    expSave   = v && op == 4'd2;
    expRecall = v && (op == 4'd1 || op == 4'd8);
    expAll    = op == 4'd8;
    if (v) begin
      if (op == 4'd10) mRd = mW[a[0]];
      if (single) mW[a[0]] = stepModel(op, mW[a[0]], d);
      if (all) begin
        mW[0] = stepModel(op, mW[0], d);
        mW[1] = stepModel(op, mW[1], d);
      end
    end
    rq = v ? reqOf(op) : "R8";
    @(negedge clk);
    cmdValid = 1'b0;
    check(wiper0 == mW[0], rq, "wiper0", wiper0, mW[0]);
    check(wiper1 == mW[1], rq, "wiper1", wiper1, mW[1]);
    check(readByte == mRd, "R10", "readByte", readByte, mRd);
    check(nvSaveReq == expSave, "R9", "nvSaveReq", nvSaveReq, expSave);
    check(nvRecallReq == expRecall, "R9", "nvRecallReq", nvRecallReq, expRecall);
    if (expSave || expRecall) begin
      check(nvChan == a[0], "R9", "nvChan", nvChan, a[0]);
      if (expRecall) check(nvAll == expAll, "R9", "nvAll", nvAll, expAll);
    end
  endtask

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd20240611);
    mW[0] = 8'd128; mW[1] = 8'd128; mRd = 8'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(wiper0 == 8'd128, "R1", "wiper0 reset", wiper0, 128);
    check(wiper1 == 8'd128, "R1", "wiper1 reset", wiper1, 128);
    check(readByte == 8'd0, "R1", "readByte reset", readByte, 0);
    check(!nvSaveReq && !nvRecallReq, "R1", "requests reset", nvSaveReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2: direct writes, address bit 0 selects the wiper
    runCmd(1, 4'd11, 4'd0, 8'd0);
    runCmd(1, 4'd11, 4'd1, 8'd200);
    // R5: doubling corners
    runCmd(1, 4'd12, 4'd0, 8'hAA);
    runCmd(1, 4'd12, 4'd0, 8'h55);
    runCmd(1, 4'd13, 4'd2, 8'd0);
    runCmd(1, 4'd11, 4'd0, 8'd128);
    runCmd(1, 4'd12, 4'd0, 8'd0);
    runCmd(1, 4'd12, 4'd0, 8'd0);
    runCmd(1, 4'd11, 4'd1, 8'd64);
    runCmd(1, 4'd12, 4'd1, 8'd3);
    // R6: halving
    runCmd(1, 4'd4, 4'd0, 8'hFF);
    runCmd(1, 4'd11, 4'd1, 8'd1);
    runCmd(1, 4'd5, 4'd0, 8'd9);
    runCmd(1, 4'd4, 4'd1, 8'd0);
    // R3 / R4: saturation, with data byte ignored (R7)
    runCmd(1, 4'd11, 4'd0, 8'd255);
    runCmd(1, 4'd14, 4'd0, 8'h12);
    runCmd(1, 4'd15, 4'd0, 8'h34);
    runCmd(1, 4'd6, 4'd1, 8'h77);
    runCmd(1, 4'd7, 4'd0, 8'h00);
    // R8: nop, unused opcode, valid low
    runCmd(1, 4'd0, 4'd0, 8'd5);
    runCmd(1, 4'd3, 4'd1, 8'd9);
    runCmd(0, 4'd11, 4'd0, 8'd33);
    // R9: nonvolatile requests
    runCmd(1, 4'd2, 4'd1, 8'd0);
    runCmd(1, 4'd1, 4'd0, 8'd0);
    runCmd(1, 4'd8, 4'd1, 8'd0);
    // R10: readback
    runCmd(1, 4'd10, 4'd0, 8'd0);
    runCmd(1, 4'd10, 4'd1, 8'd0);
    runCmd(1, 4'd14, 4'd1, 8'd0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [7:0] d;
      op = 4'($urandom_range(15, 0));
      d  = 8'($urandom);
      if ($urandom_range(3, 0) == 0) d = ($urandom_range(1, 0) == 1) ? 8'd255 : 8'd0;
      runCmd(($urandom_range(7, 0) != 0), op, 4'($urandom), d);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule